// File: doc/BRIEF.md
# Sized-Access General-Purpose Register File

This block holds sixteen 64-bit general-purpose registers. Software can reach each register at byte, word, double-word or quad-word width. Two read ports return the low 8, 16, 32 or 64 bits of any register, with zeros above the chosen width on the 64-bit bus. One write port stores a value at a chosen destination width, and every bit of the register above that width is cleared.

The write port can also perform the widening needed by move-with-extension operations. The caller gives a source size and a destination size. The low source bits of the write data are then sign- or zero-extended up to the destination width, and everything above the destination width is cleared. A size pair that the extension modes do not support raises an error flag in the same cycle, and that write is dropped.

Writes take effect on the rising clock edge, so a read in the same cycle still returns the old value. A synchronous active-high reset clears every register.

Top module: `sized_regfile`

## Requirements
- R1: A synchronous active-high reset clears all sixteen registers to zero, so every read returns zero afterwards.
- R2: The read size code selects a view: 0 gives the low 8 bits, 1 the low 16, 2 the low 32 and 3 all 64. Bits above the selected width are driven to zero on the read bus.
- R3: The two read ports are independent. Each one returns the register and view that its own index and size select.
- R4: When the write mode is 0 (plain) and the write is enabled, the register receives the low bits of the write data at the width given by the destination size code. All higher bits become zero, and size 3 writes all 64 bits.
- R5: When the write mode is 1 (sign-extend) and the source size code is below the destination size code, the source-width bits are stored and the source's top bit is copied up to the destination width. Bits above the destination width are zero.
- R6: When the write mode is 2 (zero-extend), the pairs byte to word, byte to double, byte to quad, word to double and word to quad store the source-width bits and zero every higher bit.
- R7: An enabled write is flagged on the error output in the same cycle and leaves every register unchanged in any of these cases: write mode 3; mode 1 or 2 with the source size not below the destination size; or mode 2 with source double (2) and destination quad (3).
- R8: A write becomes visible on the cycle after the clock edge that takes it. A read of the same register in the write cycle returns the old value.
- R9: The error output stays low whenever the write enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_size | input | 2 | Read port A view size code |
| rd_a_data | output | 64 | Read port A data, zero-padded |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_size | input | 2 | Read port B view size code |
| rd_b_data | output | 64 | Read port B data, zero-padded |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Destination register index |
| wr_size | input | 2 | Destination size code |
| wr_mode | input | 2 | 0 plain, 1 sign-extend, 2 zero-extend, 3 reserved |
| wr_src_size | input | 2 | Source size code for extension modes |
| wr_data | input | 64 | Write data |
| wr_err | output | 1 | Unsupported write request; the write is dropped |

## Verification
The directed cases use write data whose source sign bit is set and whose upper bits are all ones. With that data, sign extension, zero extension and plain truncation each give a different register value. A same-cycle read of the register being written shows whether the write lands a cycle late. Reading back each view after a write shows whether the view masks are correct. Seeded random operations cover every mode and every size pair, including the illegal ones, and interleave reads on both ports so that a dropped or misdirected write shows up as a mismatch on a later read.

// File: rtl/sized_regfile.sv
module sized_regfile #(
  parameter int NREGS = 16,
  parameter int XLEN  = 64
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [$clog2(NREGS)-1:0] rd_a_idx,
  input  logic [1:0]               rd_a_size,
  output logic [XLEN-1:0]          rd_a_data,
  input  logic [$clog2(NREGS)-1:0] rd_b_idx,
  input  logic [1:0]               rd_b_size,
  output logic [XLEN-1:0]          rd_b_data,
  input  logic                     wr_en,
  input  logic [$clog2(NREGS)-1:0] wr_idx,
  input  logic [1:0]               wr_size,
  input  logic [1:0]               wr_mode,
  input  logic [1:0]               wr_src_size,
  input  logic [XLEN-1:0]          wr_data,
  output logic                     wr_err
);
  localparam logic [1:0] M_PLAIN = 2'd0;
  localparam logic [1:0] M_SIGN  = 2'd1;
  localparam logic [1:0] M_ZERO  = 2'd2;

  logic [XLEN-1:0] regs [NREGS];
  logic [XLEN-1:0] src_ext, wr_value;
  logic            src_msb;

  function automatic logic [XLEN-1:0] view_mask(input logic [1:0] s);
    case (s)
      2'd0:    view_mask = XLEN'(16'h00ff);
      2'd1:    view_mask = XLEN'(16'hffff);
      2'd2:    view_mask = XLEN'(32'hffff_ffff);
      default: view_mask = '1;
    endcase
  endfunction

  always_comb begin
    case (wr_src_size)
      2'd0:    src_msb = wr_data[7];
      2'd1:    src_msb = wr_data[15];
      2'd2:    src_msb = wr_data[31];
      default: src_msb = wr_data[XLEN-1];
    endcase
  end

  always_comb begin
    case (wr_src_size)
      2'd0:    src_ext = {{(XLEN-8){src_msb && wr_mode == M_SIGN}},  wr_data[7:0]};
      2'd1:    src_ext = {{(XLEN-16){src_msb && wr_mode == M_SIGN}}, wr_data[15:0]};
      2'd2:    src_ext = {{(XLEN-32){src_msb && wr_mode == M_SIGN}}, wr_data[31:0]};
      default: src_ext = wr_data;
    endcase
  end

  assign wr_value = ((wr_mode == M_PLAIN) ? wr_data : src_ext) & view_mask(wr_size);

  assign wr_err = wr_en && (wr_mode == 2'd3 ||
                            (wr_mode != M_PLAIN && wr_src_size >= wr_size) ||
                            (wr_mode == M_ZERO && wr_src_size == 2'd2 && wr_size == 2'd3));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (wr_en && !wr_err) begin
      regs[wr_idx] <= wr_value;
    end
  end

  assign rd_a_data = regs[rd_a_idx] & view_mask(rd_a_size);
  assign rd_b_data = regs[rd_b_idx] & view_mask(rd_b_size);

  assert_reset_clears_R1: assert property (@(posedge clk)
    $past(rst) |-> (rd_a_data == '0 && rd_b_data == '0));

  assert_err_no_write_R7: assert property (@(posedge clk) disable iff (rst)
    wr_err |=> regs[$past(wr_idx)] == $past(regs[wr_idx]));

  assert_byte_clears_upper_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_err && wr_size == 2'd0) |=> regs[$past(wr_idx)][XLEN-1:8] == '0);

  assert_sign_to_quad_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_err && wr_mode == M_SIGN && wr_size == 2'd3)
      |=> regs[$past(wr_idx)][XLEN-1] == $past(src_msb));

  assert_zero_to_quad_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_err && wr_mode == M_ZERO && wr_size == 2'd3)
      |=> regs[$past(wr_idx)][XLEN-1:32] == '0);

  assert_err_needs_enable_R9: assert property (@(posedge clk) disable iff (rst)
    !wr_en |-> !wr_err);
endmodule

// File: tb/sized_regfile_bench.sv
module sized_regfile_bench;
  logic clk = 0;
  always #2 clk = ~clk;

  logic        rst;
  logic [3:0]  rd_a_idx, rd_b_idx, wr_idx;
  logic [1:0]  rd_a_size, rd_b_size, wr_size, wr_mode, wr_src_size;
  logic [63:0] rd_a_data, rd_b_data, wr_data;
  logic        wr_en, wr_err;

  sized_regfile u_sized_regfile (.*);

  logic [63:0] model [16];
  int checks = 0;
  int fails  = 0;

  function automatic logic [63:0] msk(input logic [1:0] s);
    return (s == 2'd3) ? 64'hffff_ffff_ffff_ffff : ((64'd1 << (8 * (1 << s))) - 64'd1);
  endfunction

  function automatic bit illegal(input logic [1:0] m, input logic [1:0] src, input logic [1:0] dst);
    return (m == 2'd3) || (m != 2'd0 && src >= dst) || (m == 2'd2 && src == 2'd2 && dst == 2'd3);
  endfunction

  function automatic logic [63:0] expect_val(input logic [1:0] m, input logic [1:0] src,
                                             input logic [1:0] dst, input logic [63:0] d);
    logic [63:0] v;
    if (m == 2'd0) return d & msk(dst);
    v = d & msk(src);
    if (m == 2'd1 && d[8 * (1 << src) - 1]) v = v | ~msk(src);
    return v & msk(dst);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [3:0] wi, input logic [1:0] ws,
                      input logic [1:0] wm, input logic [1:0] wsrc, input logic [63:0] wd,
                      input logic [3:0] ai, input logic [1:0] as_, input logic [3:0] bi,
                      input logic [1:0] bs, input string tag);
    @(negedge clk);
    wr_en = we; wr_idx = wi; wr_size = ws; wr_mode = wm; wr_src_size = wsrc; wr_data = wd;
    rd_a_idx = ai; rd_a_size = as_; rd_b_idx = bi; rd_b_size = bs;
    #1;
    chk({tag, " R2 R3 R8 port A"}, rd_a_data, model[ai] & msk(as_));
    chk({tag, " R2 R3 R8 port B"}, rd_b_data, model[bi] & msk(bs));
    chk({tag, " R7 R9 error"}, {63'd0, wr_err}, {63'd0, we && illegal(wm, wsrc, ws)});
    @(posedge clk);
    if (we && !illegal(wm, wsrc, ws)) model[wi] = expect_val(wm, wsrc, ws, wd);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) model[i] = '0;
    rst = 1; wr_en = 0; wr_idx = 0; wr_size = 0; wr_mode = 0; wr_src_size = 0; wr_data = 0;
    rd_a_idx = 0; rd_a_size = 3; rd_b_idx = 0; rd_b_size = 3;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;

    // R1: every register reads zero after reset
    for (int i = 0; i < 16; i += 2) step(0, 0, 0, 0, 0, 0, 4'(i), 3, 4'(i + 1), 3, "R1");

    // R4 full quad write, R8 same-cycle read sees old value
    step(1, 5, 3, 0, 0, 64'h8123_4567_89ab_cdef, 5, 3, 5, 0, "R4 R8");
    chk("R8 old value", model[5], 64'h8123_4567_89ab_cdef);
    // R2 each view of the stored value
    step(0, 0, 0, 0, 0, 0, 5, 0, 5, 1, "R2 views");
    chk("R2 byte", rd_a_data, 64'hef);
    chk("R2 word", rd_b_data, 64'hcdef);
    step(0, 0, 0, 0, 0, 0, 5, 2, 5, 3, "R2 views");
    chk("R2 double", rd_a_data, 64'h89ab_cdef);
    // R4 narrow plain write clears upper bits
    step(1, 5, 0, 0, 0, 64'hffff_ffff_ffff_ff7e, 5, 3, 0, 3, "R4");
    step(0, 0, 0, 0, 0, 0, 5, 3, 0, 3, "R4");
    chk("R4 byte plain", rd_a_data, 64'h7e);
    // R5 sign extension pairs
    step(1, 6, 1, 1, 0, 64'hffff_ffff_ffff_ff80, 6, 3, 0, 3, "R5");
    step(1, 7, 3, 1, 0, 64'h0000_0000_0000_0080, 6, 3, 0, 3, "R5");
    chk("R5 byte to word", rd_a_data, 64'hff80);
    step(1, 8, 2, 1, 1, 64'h0000_0000_1234_8001, 7, 3, 0, 3, "R5");
    chk("R5 byte to quad", rd_a_data, 64'hffff_ffff_ffff_ff80);
    step(0, 0, 0, 0, 0, 0, 8, 3, 0, 3, "R5");
    chk("R5 word to double", rd_a_data, 64'hffff_8001);
    // R6 zero extension
    step(1, 9, 3, 2, 0, 64'hffff_ffff_ffff_fff0, 9, 3, 0, 3, "R6");
    step(0, 0, 0, 0, 0, 0, 9, 3, 0, 3, "R6");
    chk("R6 byte to quad", rd_a_data, 64'hf0);
    // R7 illegal requests leave register 5 unchanged
    step(1, 5, 3, 2, 2, 64'h1111_2222_3333_4444, 5, 3, 0, 3, "R7 zero double-quad");
    step(1, 5, 3, 3, 0, 64'h5555_6666_7777_8888, 5, 3, 0, 3, "R7 mode 3");
    step(1, 5, 1, 1, 1, 64'h9999_aaaa_bbbb_cccc, 5, 3, 0, 3, "R7 same size");
    step(0, 5, 1, 3, 1, 64'hdddd, 5, 3, 0, 3, "R9 disabled");
    chk("R7 register kept", rd_a_data, 64'h7e);

    for (int n = 0; n < 3000; n++) begin
      step(1'($urandom % 4 != 0), 4'($urandom), 2'($urandom), 2'($urandom), 2'($urandom),
           {$urandom, $urandom}, 4'($urandom), 2'($urandom), 4'($urandom), 2'($urandom),
           "R4 R5 R6 R7 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule